// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the word address for a synchronous burst memory port. A clock edge that sees one of two address strobes loads an external address into a holding register and clears a small beat counter. The processor-side strobe needs the chip enable to be active. The controller-side strobe always loads. Each later edge with the advance input high steps the beat counter by one. The output address is the loaded upper field joined to low bits derived from the loaded low bits and the beat count.

A static order input picks how the low bits move. In linear order they count up and wrap around. In interleaved order they are the loaded low bits XOR the beat count. The upper address field does not change until the next load. The first address is on the output in the cycle after the load edge, and each advance edge gives the next beat. This yields a 2-1-1-1 access rhythm. The chip-enable level seen at each load is also kept, so a downstream stage can tell a selected burst from a deselected one.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_n is low and after its release, before any load, addr_out, beat_idx and sel_q are all zero.
- R2: An edge with ctl_stb high loads addr_in whatever the level of chip_en. After that edge addr_out equals the loaded address and beat_idx is 0.
- R3: An edge with cpu_stb high and chip_en high loads like R2. An edge with cpu_stb high, chip_en low and ctl_stb low loads nothing, and addr_out and beat_idx only do what adv asks.
- R4: On every load, sel_q takes the chip_en level of that edge (1 = selected) and keeps it until the next load.
- R5: An edge with adv high and no load raises beat_idx by one, modulo 4 for the default 2-bit counter (3 goes to 0).
- R6: With order_sel = 0 (linear), addr_out[1:0] equals (loaded low bits + beat_idx) mod 4.
- R7: With order_sel = 1 (interleaved), addr_out[1:0] equals the loaded low bits XOR beat_idx.
- R8: addr_out[ADDR_W-1:2] changes only on a load edge.
- R9: A load and an advance on the same edge act as a load, so beat_idx is 0 afterwards.
- R10: An edge with no load and adv low leaves addr_out, beat_idx and sel_q unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_stb | input | 1 | Processor-side address strobe, qualified by chip_en |
| ctl_stb | input | 1 | Controller-side address strobe, unqualified |
| chip_en | input | 1 | Chip enable, sampled at a load |
| adv | input | 1 | Advance to the next beat |
| order_sel | input | 1 | Static order: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External address to load |
| addr_out | output | ADDR_W | Current burst word address |
| beat_idx | output | BURST_W | Position inside the burst |
| sel_q | output | 1 | Chip enable captured at the last load |

## Verification
A load and an advance can arrive on the same edge. The rule is that the load wins and the beat count restarts at zero. The bench raises adv together with a strobe in the middle of a running burst. It expects beat 0 and the new address on the next cycle, not the old burst stepped by one. It also pairs a processor strobe that has chip enable low with an advance, so the advance has to act alone while the ignored strobe has no effect.

// File: rtl/bag_pkg.sv
package bag_pkg;
   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } order_e;

   typedef enum logic [1:0] {
      SUP_BOTH       = 2'd0,
      SUP_LINEAR     = 2'd1,
      SUP_INTERLEAVE = 2'd2
   } support_e;
endpackage

// File: rtl/bag_load_ctrl.sv
module bag_load_ctrl (
   input  logic cpu_stb,
   input  logic ctl_stb,
   input  logic chip_en,
   input  logic adv,
   output logic load,
   output logic step
);
   logic cpu_ok;

   always_comb begin
      cpu_ok = cpu_stb & chip_en;
      load   = ctl_stb | cpu_ok;
      step   = adv & ~load;
   end
endmodule

// File: rtl/bag_base_reg.sv
module bag_base_reg #(
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              chip_en,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] base,
   output logic              sel
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base <= '0;
         sel  <= 1'b0;
      end else if (load) begin
         base <= addr_in;
         sel  <= chip_en;
      end
   end
endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr #(
   parameter int BURST_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               step,
   output logic [BURST_W-1:0] cnt
);
   localparam logic [BURST_W-1:0] ONE = BURST_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= '0;
      end else if (step) begin
         cnt <= cnt + ONE;
      end
   end
endmodule

// File: rtl/bag_order_map.sv
module bag_order_map
   import bag_pkg::*;
#(
   parameter int       BURST_W = 2,
   parameter support_e SUPPORT = SUP_BOTH
) (
   input  logic [BURST_W-1:0] base_lo,
   input  logic [BURST_W-1:0] cnt,
   input  logic               order_sel,
   output logic [BURST_W-1:0] lo
);
   logic [BURST_W-1:0] lin_lo;
   logic [BURST_W-1:0] ilv_lo;

   always_comb lin_lo = base_lo + cnt;

   for (genvar b = 0; b < BURST_W; b++) begin : g_ilv
      assign ilv_lo[b] = base_lo[b] ^ cnt[b];
   end

   if (SUPPORT == SUP_LINEAR) begin : g_lin_only
      assign lo = lin_lo;
   end else if (SUPPORT == SUP_INTERLEAVE) begin : g_ilv_only
      assign lo = ilv_lo;
   end else begin : g_both
      always_comb begin
         if (order_e'(order_sel) == ORD_INTERLEAVE) lo = ilv_lo;
         else                                       lo = lin_lo;
      end
   end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import bag_pkg::*;
#(
   parameter int       ADDR_W  = 20,
   parameter int       BURST_W = 2,
   parameter support_e SUPPORT = SUP_BOTH
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_stb,
   input  logic               ctl_stb,
   input  logic               chip_en,
   input  logic               adv,
   input  logic               order_sel,
   input  logic [ADDR_W-1:0]  addr_in,
   output logic [ADDR_W-1:0]  addr_out,
   output logic [BURST_W-1:0] beat_idx,
   output logic               sel_q
);
   localparam int HI_W = ADDR_W - BURST_W;

   if (BURST_W < 1) begin : g_bad_burst
      $error("BURST_W must be at least 1");
   end
   if (HI_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed BURST_W");
   end

   logic               load;
   logic               step;
   logic [ADDR_W-1:0]  base;
   logic [BURST_W-1:0] cnt;
   logic [BURST_W-1:0] lo;

   bag_load_ctrl u_ctrl (
      .cpu_stb (cpu_stb),
      .ctl_stb (ctl_stb),
      .chip_en (chip_en),
      .adv     (adv),
      .load    (load),
      .step    (step)
   );

   bag_base_reg #(.ADDR_W(ADDR_W)) u_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .chip_en (chip_en),
      .addr_in (addr_in),
      .base    (base),
      .sel     (sel_q)
   );

   bag_beat_ctr #(.BURST_W(BURST_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .step  (step),
      .cnt   (cnt)
   );

   bag_order_map #(.BURST_W(BURST_W), .SUPPORT(SUPPORT)) u_map (
      .base_lo   (base[BURST_W-1:0]),
      .cnt       (cnt),
      .order_sel (order_sel),
      .lo        (lo)
   );

   always_comb begin
      addr_out = {base[ADDR_W-1:BURST_W], lo};
      beat_idx = cnt;
   end
endmodule

// File: rtl/bag_chk.sv
module bag_chk #(
   parameter int ADDR_W  = 20,
   parameter int BURST_W = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cpu_stb,
   input logic               ctl_stb,
   input logic               chip_en,
   input logic               adv,
   input logic               order_sel,
   input logic [ADDR_W-1:0]  addr_in,
   input logic [ADDR_W-1:0]  addr_out,
   input logic [BURST_W-1:0] beat_idx,
   input logic               sel_q
);
   logic ld;
   always_comb ld = ctl_stb | (cpu_stb & chip_en);

   // R2
   load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (addr_out == $past(addr_in)) && (beat_idx == '0));

   // R4
   load_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> sel_q == $past(chip_en));

   // R5
   adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && adv) |=> beat_idx == BURST_W'($past(beat_idx) + 1'b1));

   // R8
   hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(addr_out[ADDR_W-1:BURST_W]));

   // R9
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && adv) |=> beat_idx == '0);

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !adv) |=> $stable(beat_idx) && $stable(sel_q));

   // R3
   cpu_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_stb && !chip_en && !ctl_stb && !adv) |=> $stable(beat_idx));
endmodule

bind burst_addr_gen bag_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (.*);

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;
   localparam int AW = 20;

   typedef struct {
      logic [AW-1:0] addr;
      logic [1:0]    beat;
      logic          sel;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_stb = 1'b0, ctl_stb = 1'b0, chip_en = 1'b0, adv = 1'b0;
   logic          order_sel = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic [AW-1:0] addr_out;
   logic [1:0]    beat_idx;
   logic          sel_q;

   int n_chk = 0;
   int n_bad = 0;
   exp_t sb[$];

   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_cnt = '0;
   logic          m_sel = 1'b0;

   always #2 clk = ~clk;

   burst_addr_gen dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_stb(cpu_stb), .ctl_stb(ctl_stb),
      .chip_en(chip_en), .adv(adv), .order_sel(order_sel),
      .addr_in(addr_in), .addr_out(addr_out), .beat_idx(beat_idx),
      .sel_q(sel_q)
   );

   task automatic check(input string tag, input logic [AW-1:0] a, input logic [1:0] b,
                        input logic s, input logic [AW-1:0] ea, input logic [1:0] eb,
                        input logic es);
      n_chk++;
      if (a !== ea || b !== eb || s !== es) begin
         n_bad++;
         $display("FAIL %s: addr=%h beat=%0d sel=%b expected addr=%h beat=%0d sel=%b",
                  tag, a, b, s, ea, eb, es);
      end
   endtask

   task automatic step(input logic c, input logic k, input logic e, input logic a,
                       input logic [AW-1:0] ad, input logic ord, input string tag);
      exp_t it;
      logic [1:0] lo;
      @(negedge clk);
      cpu_stb = c; ctl_stb = k; chip_en = e; adv = a; addr_in = ad; order_sel = ord;
      if (k || (c && e)) begin
         m_base = ad; m_cnt = 2'd0; m_sel = e;
      end else if (a) begin
         m_cnt = m_cnt + 2'd1;
      end
      lo = ord ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
      it.addr = {m_base[AW-1:2], lo};
      it.beat = m_cnt;
      it.sel  = m_sel;
      it.tag  = tag;
      sb.push_back(it);
   endtask

   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         exp_t it;
         it = sb.pop_front();
         check(it.tag, addr_out, beat_idx, sel_q, it.addr, it.beat, it.sel);
      end
   end

   task automatic finish_run();
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 in reset", addr_out, beat_idx, sel_q, '0, 2'd0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", addr_out, beat_idx, sel_q, '0, 2'd0, 1'b0);

      // R2 controller strobe loads with chip enable low; R4 sel captured 0
      step(0, 1, 0, 0, 20'hABCD0, 0, "R2 R4 ctl load ce=0");
      // R5 R6 linear advances and wrap
      step(0, 0, 0, 1, 20'h0, 0, "R5 R6 adv1");
      step(0, 0, 0, 1, 20'h0, 0, "R5 R6 adv2");
      step(0, 0, 0, 1, 20'h0, 0, "R5 R6 adv3");
      step(0, 0, 0, 1, 20'h0, 0, "R5 wrap to 0");
      // R10 idle holds
      step(0, 0, 1, 0, 20'h11111, 0, "R10 idle hold");
      // R3 processor strobe with chip enable high; R4 sel=1; R6 R8 from low bits 2
      step(1, 0, 1, 0, 20'h3C00E, 0, "R3 R4 cpu load ce=1");
      step(0, 0, 0, 1, 20'h0, 0, "R6 R8 lin 3");
      step(0, 0, 0, 1, 20'h0, 0, "R6 R8 lin wrap 0");
      step(0, 0, 0, 1, 20'h0, 0, "R6 R8 lin 1");
      // R3 ignored cpu strobe, with and without advance
      step(1, 0, 0, 0, 20'hFFFFF, 0, "R3 cpu ce=0 ignored");
      step(1, 0, 0, 1, 20'hFFFFF, 0, "R3 cpu ce=0 adv only");
      // R7 interleaved from low bits 1
      step(0, 1, 1, 0, 20'h55551, 1, "R7 ilv load");
      step(0, 0, 0, 1, 20'h0, 1, "R7 ilv b1");
      step(0, 0, 0, 1, 20'h0, 1, "R7 ilv b2");
      step(0, 0, 0, 1, 20'h0, 1, "R7 ilv b3");
      // R9 load with advance mid-burst
      step(0, 0, 0, 1, 20'h0, 1, "R5 ilv wrap");
      step(0, 0, 0, 1, 20'h0, 1, "R5 ilv b1 again");
      step(1, 0, 1, 1, 20'h02463, 1, "R9 load beats adv");
      step(0, 1, 0, 1, 20'h8ACE2, 0, "R9 ctl load beats adv");
      step(0, 0, 0, 0, 20'h0, 0, "R10 R8 idle after load");
      // R7 interleaved from low bits 3
      step(0, 1, 1, 1, 20'h7777B, 1, "R7 R9 ilv load 3");
      step(0, 0, 0, 1, 20'h0, 1, "R7 ilv 2");
      step(0, 0, 0, 1, 20'h0, 1, "R7 ilv 1");
      step(0, 0, 0, 1, 20'h0, 1, "R7 ilv 0");
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule